// File: doc/BRIEF.md
# Logarithmic-Domain Multiplier/Divider

This block multiplies or divides two normalized floating-style operands without a multiplier array or an iterative divider. Each operand is a mantissa in [1.0, 2.0), carried as its 8-bit fraction, together with a small signed power-of-two exponent. Both fractions are mapped to base-2 logarithms through one shared two-port lookup table. A single 9-bit adder then sums the logarithms for a product or takes their difference for a quotient. A second lookup table maps the combined fraction back to a linear mantissa.

The datapath is a three-stage pipeline: log lookup, then add/subtract with exponent update, then antilog lookup. It accepts a new operand pair on every clock, with no back-pressure. A mode bit selects multiply or divide per operand pair. A result-valid output follows the input strobe. Both tables are computed when the design is elaborated. The antilog table can include a fixed scale factor, which makes every result also multiplied by that constant at no cost in logic or cycles. Raw integers must be normalized before they reach the block. Signs and exceptions are handled outside it.

Top module: `lns_muldiv`

## Requirements
- R1: `out_valid_o` is high exactly three rising clock edges after `in_valid_i` was sampled high, and low three edges after it was sampled low.
- R2: A new operand pair is accepted on every clock cycle, including back-to-back pairs with different modes and pairs separated by idle cycles; each result belongs to the pair sampled three edges earlier.
- R3: With `mode_i` = 0 (multiply), the value (1 + res_frac_o/256)·2^res_exp_o is within a relative error of 3/256 of (1 + a_frac_i/256)·(1 + b_frac_i/256)·2^(a_exp_i + b_exp_i).
- R4: With `mode_i` = 1 (divide), the result value is within a relative error of 3/256 of the quotient of operand A by operand B, with exponent a_exp_i − b_exp_i applied.
- R5: In multiply mode, when the sum of the two 9-bit log values reaches 256 (product mantissa at least 2.0), `res_exp_o` = a_exp_i + b_exp_i + 1; otherwise it is a_exp_i + b_exp_i.
- R6: In divide mode, when the log of A is below the log of B (quotient mantissa below 1.0), `res_exp_o` = a_exp_i − b_exp_i − 1 and the fraction difference wraps modulo 256; otherwise `res_exp_o` = a_exp_i − b_exp_i.
- R7: With unit scale, multiplying two operands whose fractions are both 0 gives `res_frac_o` = 0, and dividing two operands with equal fractions gives `res_frac_o` = 0, both with the exponents combined exactly.
- R8: The log table entry k is round(log2(1 + k/256)·256). The antilog table entry j is round((2^(j/256)·s − 1)·256), clamped to [0, 255], where s = SCALE_Q8/256 (default 256, i.e. s = 1.0). With SCALE_Q8 = 320, 1.0 × 1.0 gives fraction 64 and exponent 0.
- R9: While `rst_ni` is low, `out_valid_o`, `res_frac_o` and `res_exp_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair present this cycle |
| mode_i | input | 1 | 0 = multiply, 1 = divide |
| a_frac_i | input | 8 | Fraction of mantissa A (value 1 + a_frac_i/256) |
| a_exp_i | input | EXP_W | Signed exponent of A |
| b_frac_i | input | 8 | Fraction of mantissa B |
| b_exp_i | input | EXP_W | Signed exponent of B |
| out_valid_o | output | 1 | Result present this cycle |
| res_frac_o | output | 8 | Fraction of result mantissa |
| res_exp_o | output | EXP_W+2 | Signed exponent of result |

## Verification
Every result is due on the third rising edge after its operands were sampled: one edge to register the two log lookups, one for the add/subtract and exponent update, and one for the antilog lookup. The bench drives operands on falling edges and compares outputs on falling edges. The output seen at the falling edge three cycles after a drive therefore belongs to that drive. The bench also keeps an index delay of three, so back-to-back streams, idle gaps and alternating modes are matched pair by pair. The valid flag is checked in every cycle of a burst, and in the first cycle after the burst drains.

// File: rtl/lnsmd_pkg.sv
package lnsmd_pkg;
  localparam int FRAC_W = 8;
  localparam int LOG_W  = FRAC_W + 1;
  localparam int DEPTH  = 1 << FRAC_W;

  // log2(1 + k/256) * 256, by repeated squaring in Q16
  function automatic int log_entry(int k);
    longint m;
    int r;
    m = longint'(DEPTH + k) << (16 - FRAC_W);
    r = 0;
    for (int i = 0; i < 12; i++) begin
      m = (m * m) >> 16;
      r = r << 1;
      if (m >= 64'sd131072) begin
        m = m >> 1;
        r = r | 1;
      end
    end
    return (r + 8) >> 4;
  endfunction

  // 2^(2^b / 256) in Q20
  function automatic longint root_q20(int b);
    case (b)
      0: return 64'sd1051419;
      1: return 64'sd1054270;
      2: return 64'sd1059994;
      3: return 64'sd1071537;
      4: return 64'sd1095000;
      5: return 64'sd1143480;
      6: return 64'sd1246975;
      default: return 64'sd1482910;
    endcase
  endfunction

  // (2^(j/256) * scale - 1) * 256, clamped
  function automatic int alog_entry(int j, int scale_q8);
    longint p;
    longint t;
    p = longint'(1) << 20;
    for (int b = 0; b < FRAC_W; b++)
      if (((j >> b) & 1) == 1) p = (p * root_q20(b)) >> 20;
    t = (p * longint'(scale_q8) + (longint'(1) << 19)) >> 20;
    t = t - DEPTH;
    if (t < 0) t = 0;
    if (t > DEPTH - 1) t = DEPTH - 1;
    return int'(t);
  endfunction
endpackage

// File: rtl/lnsmd_log_rom.sv
module lnsmd_log_rom
  import lnsmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] addr_a_i,
  input  logic [FRAC_W-1:0] addr_b_i,
  output logic [LOG_W-1:0]  q_a_o,
  output logic [LOG_W-1:0]  q_b_o
);
  logic [LOG_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    localparam logic [LOG_W-1:0] ENT = LOG_W'(log_entry(k));
    assign tbl[k] = ENT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_a_o <= '0;
      q_b_o <= '0;
    end else begin
      q_a_o <= tbl[addr_a_i];
      q_b_o <= tbl[addr_b_i];
    end
  end
endmodule

// File: rtl/lnsmd_addsub.sv
module lnsmd_addsub
  import lnsmd_pkg::*;
#(
  parameter int EXP_W = 6,
  localparam int RES_W = EXP_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    div_i,
  input  logic [LOG_W-1:0]        log_a_i,
  input  logic [LOG_W-1:0]        log_b_i,
  input  logic signed [EXP_W-1:0] exp_a_i,
  input  logic signed [EXP_W-1:0] exp_b_i,
  output logic                    valid_o,
  output logic [FRAC_W-1:0]       frac_o,
  output logic signed [RES_W-1:0] exp_o
);
  logic [LOG_W-1:0]        sum, diff;
  logic                    carry, borrow;
  logic signed [RES_W-1:0] ea_x, eb_x, exp_n;
  logic [FRAC_W-1:0]       frac_n;

  always_comb begin
    sum    = log_a_i + log_b_i;
    diff   = log_a_i - log_b_i;
    carry  = sum[FRAC_W];
    borrow = diff[FRAC_W];
    ea_x   = {{(RES_W-EXP_W){exp_a_i[EXP_W-1]}}, exp_a_i};
    eb_x   = {{(RES_W-EXP_W){exp_b_i[EXP_W-1]}}, exp_b_i};
    if (div_i) begin
      frac_n = diff[FRAC_W-1:0];
      exp_n  = ea_x - eb_x - {{(RES_W-1){1'b0}}, borrow};
    end else begin
      frac_n = sum[FRAC_W-1:0];
      exp_n  = ea_x + eb_x + {{(RES_W-1){1'b0}}, carry};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      frac_o  <= '0;
      exp_o   <= '0;
    end else begin
      valid_o <= valid_i;
      frac_o  <= frac_n;
      exp_o   <= exp_n;
    end
  end
endmodule

// File: rtl/lnsmd_alog_rom.sv
module lnsmd_alog_rom
  import lnsmd_pkg::*;
#(
  parameter int SCALE_Q8 = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] addr_i,
  output logic [FRAC_W-1:0] q_o
);
  logic [FRAC_W-1:0] tbl [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    localparam logic [FRAC_W-1:0] ENT = FRAC_W'(alog_entry(j, SCALE_Q8));
    assign tbl[j] = ENT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= tbl[addr_i];
  end
endmodule

// File: rtl/lns_muldiv.sv
module lns_muldiv
  import lnsmd_pkg::*;
#(
  parameter int EXP_W    = 6,
  parameter int SCALE_Q8 = 256,
  localparam int RES_W   = EXP_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic                    mode_i,
  input  logic [FRAC_W-1:0]       a_frac_i,
  input  logic signed [EXP_W-1:0] a_exp_i,
  input  logic [FRAC_W-1:0]       b_frac_i,
  input  logic signed [EXP_W-1:0] b_exp_i,
  output logic                    out_valid_o,
  output logic [FRAC_W-1:0]       res_frac_o,
  output logic signed [RES_W-1:0] res_exp_o
);
  // stage 1: log lookup, sidebands
  logic [LOG_W-1:0]        s1_log_a, s1_log_b;
  logic                    s1_valid, s1_div;
  logic signed [EXP_W-1:0] s1_exp_a, s1_exp_b;

  lnsmd_log_rom u_log (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_a_i (a_frac_i),
    .addr_b_i (b_frac_i),
    .q_a_o    (s1_log_a),
    .q_b_o    (s1_log_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_div   <= 1'b0;
      s1_exp_a <= '0;
      s1_exp_b <= '0;
    end else begin
      s1_valid <= in_valid_i;
      s1_div   <= mode_i;
      s1_exp_a <= a_exp_i;
      s1_exp_b <= b_exp_i;
    end
  end

  // stage 2: combine logs, exponent update
  logic                    s2_valid;
  logic [FRAC_W-1:0]       s2_frac;
  logic signed [RES_W-1:0] s2_exp;

  lnsmd_addsub #(.EXP_W(EXP_W)) u_addsub (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .div_i   (s1_div),
    .log_a_i (s1_log_a),
    .log_b_i (s1_log_b),
    .exp_a_i (s1_exp_a),
    .exp_b_i (s1_exp_b),
    .valid_o (s2_valid),
    .frac_o  (s2_frac),
    .exp_o   (s2_exp)
  );

  // stage 3: antilog lookup
  lnsmd_alog_rom #(.SCALE_Q8(SCALE_Q8)) u_alog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (s2_frac),
    .q_o    (res_frac_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      res_exp_o   <= '0;
    end else begin
      out_valid_o <= s2_valid;
      res_exp_o   <= s2_exp;
    end
  end
endmodule

// File: rtl/lns_muldiv_chk.sv
module lns_muldiv_chk
  import lnsmd_pkg::*;
#(
  parameter int SCALE_Q8 = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              mode_i,
  input logic [FRAC_W-1:0] a_frac_i,
  input logic [FRAC_W-1:0] b_frac_i,
  input logic              out_valid_o,
  input logic [FRAC_W-1:0] res_frac_o
);
  localparam bit UNITY = (SCALE_Q8 == 256);

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##3 out_valid_o);

  // R1
  idle_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##3 !out_valid_o);

  // R7
  div_same_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (UNITY && in_valid_i && mode_i && (a_frac_i == b_frac_i)) |-> ##3 (res_frac_o == '0));

  // R7
  mul_unit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (UNITY && in_valid_i && !mode_i && (a_frac_i == '0) && (b_frac_i == '0))
      |-> ##3 (res_frac_o == '0));
endmodule

bind lns_muldiv lns_muldiv_chk #(.SCALE_Q8(SCALE_Q8)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .mode_i      (mode_i),
  .a_frac_i    (a_frac_i),
  .b_frac_i    (b_frac_i),
  .out_valid_o (out_valid_o),
  .res_frac_o  (res_frac_o)
);

// File: tb/sim_lns_muldiv.sv
`timescale 1ns/1ps
module sim_lns_muldiv;
  localparam int EW = 6;
  localparam int RW = EW + 2;
  localparam int NOX = 9999;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_v = 1'b0, md = 1'b0;
  logic [7:0] fa = '0, fb = '0;
  logic signed [EW-1:0] ea = '0, eb = '0;
  logic ov0, ov1;
  logic [7:0] rf0, rf1;
  logic signed [RW-1:0] re0, re1;

  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  lns_muldiv #(.EXP_W(EW), .SCALE_Q8(256)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_v), .mode_i(md),
    .a_frac_i(fa), .a_exp_i(ea), .b_frac_i(fb), .b_exp_i(eb),
    .out_valid_o(ov0), .res_frac_o(rf0), .res_exp_o(re0));

  lns_muldiv #(.EXP_W(EW), .SCALE_Q8(320)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_v), .mode_i(md),
    .a_frac_i(fa), .a_exp_i(ea), .b_frac_i(fb), .b_exp_i(eb),
    .out_valid_o(ov1), .res_frac_o(rf1), .res_exp_o(re1));

  // stimulus table
  int q_fa[64], q_fb[64], q_ea[64], q_eb[64], q_md[64], q_v[64], q_xe[64], q_xf[64];

  function automatic real pow2r(int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else        for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input real act, input real exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %f expected %f", tag, what, act, exp);
    end
  endtask

  task automatic clear_q();
    for (int i = 0; i < 64; i++) begin
      q_v[i] = 0; q_xe[i] = NOX; q_xf[i] = -1;
    end
  endtask

  task automatic set_q(int i, int a, int b, int xa, int xb, int m);
    q_fa[i] = a; q_fb[i] = b; q_ea[i] = xa; q_eb[i] = xb; q_md[i] = m; q_v[i] = 1;
  endtask

  // drive n entries on falling edges; output for entry i appears three edges later
  task automatic run_burst(input int n, input string tag, input bit alt);
    for (int c = 0; c < n + 4; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        int i = c - 3;
        int ev = (i < n) ? q_v[i] : 0;
        logic gv = alt ? ov1 : ov0;
        check(gv == ev[0], "R1", "valid", real'(gv), real'(ev));
        if (i < n && ev != 0) begin
          real sc = alt ? 1.25 : 1.0;
          real ma = 1.0 + q_fa[i] / 256.0;
          real mb = 1.0 + q_fb[i] / 256.0;
          real ref_v = q_md[i] != 0 ? ma / mb * pow2r(q_ea[i] - q_eb[i])
                                    : ma * mb * pow2r(q_ea[i] + q_eb[i]);
          int gf = alt ? int'(rf1) : int'(rf0);
          int ge = alt ? int'(re1) : int'(re0);
          real got = (1.0 + gf / 256.0) * pow2r(ge);
          real err;
          ref_v = ref_v * sc;
          err = got / ref_v - 1.0;
          if (err < 0.0) err = -err;
          check(err <= 3.0 / 256.0, tag, "value", got, ref_v);
          if (q_xe[i] != NOX) check(ge == q_xe[i], tag, "exponent", real'(ge), real'(q_xe[i]));
          if (q_xf[i] >= 0)   check(gf == q_xf[i], tag, "fraction", real'(gf), real'(q_xf[i]));
        end
      end
      if (c < n) begin
        in_v = q_v[c][0]; md = q_md[c][0];
        fa = q_fa[c][7:0]; fb = q_fb[c][7:0];
        ea = q_ea[c][EW-1:0]; eb = q_eb[c][EW-1:0];
      end else begin
        in_v = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(ov0 == 1'b0 && rf0 == '0 && re0 == '0, "R9", "reset outputs",
            real'(rf0) + real'(ov0), 0.0);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_identity();  // R7
    clear_q();
    set_q(0, 0, 0, 3, -2, 0);      q_xe[0] = 1;  q_xf[0] = 0;
    set_q(1, 100, 100, 2, 5, 1);   q_xe[1] = -3; q_xf[1] = 0;
    set_q(2, 255, 255, -4, -4, 1); q_xe[2] = 0;  q_xf[2] = 0;
    run_burst(3, "R7", 1'b0);
  endtask

  task automatic t_carry();  // R5
    clear_q();
    set_q(0, 128, 128, 0, 0, 0);  q_xe[0] = 1;
    set_q(1, 0, 255, 2, 1, 0);    q_xe[1] = 3;
    set_q(2, 200, 180, -3, 1, 0); q_xe[2] = -1;
    set_q(3, 10, 20, -1, -1, 0);  q_xe[3] = -2;
    run_burst(4, "R5", 1'b0);
  endtask

  task automatic t_borrow();  // R6
    clear_q();
    set_q(0, 0, 128, 0, 0, 1);   q_xe[0] = -1;
    set_q(1, 200, 100, 0, 0, 1); q_xe[1] = 0;
    set_q(2, 5, 250, 3, -2, 1);  q_xe[2] = 4;
    set_q(3, 250, 5, -3, 2, 1);  q_xe[3] = -5;
    run_burst(4, "R6", 1'b0);
  endtask

  task automatic t_mul_sweep();  // R3, R2
    clear_q();
    for (int i = 0; i < 40; i++) set_q(i, (i * 37) % 256, (i * 91 + 13) % 256, (i % 7) - 3, (i % 5) - 2, 0);
    run_burst(40, "R3", 1'b0);
  endtask

  task automatic t_div_sweep();  // R4, R2
    clear_q();
    for (int i = 0; i < 40; i++) set_q(i, (i * 53 + 7) % 256, (i * 29 + 101) % 256, (i % 9) - 4, (i % 4) - 1, 1);
    run_burst(40, "R4", 1'b0);
  endtask

  task automatic t_mixed();  // R2: alternating modes with idle gaps
    clear_q();
    for (int i = 0; i < 30; i++) begin
      set_q(i, (i * 71) % 256, (i * 17 + 3) % 256, (i % 6) - 3, (i % 3) - 1, i % 2);
      if (i % 3 == 1) q_v[i] = 0;
    end
    run_burst(30, "R2", 1'b0);
  endtask

  task automatic t_scale();  // R8
    clear_q();
    set_q(0, 0, 0, 0, 0, 0);   q_xe[0] = 0; q_xf[0] = 64;
    set_q(1, 0, 64, 1, 0, 0);
    run_burst(2, "R8", 1'b1);
  endtask

  initial begin
    t_reset();
    t_identity();
    t_carry();
    t_borrow();
    t_mul_sweep();
    t_div_sweep();
    t_mixed();
    t_scale();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule